// File: doc/BRIEF.md
# Concurrent Row/Column Transpose Buffer

This block sits between two one-dimensional transform stages and turns the vectors produced by the first stage into transposed vectors for the second. It holds a square array of LANES by LANES register cells. Each cycle that the input is marked valid, the block takes one LANES-wide vector, writes it into one line of the array, and in the same cycle reads one line of the array out. The read happens before the write, so the vector read out always belongs to the previous block of LANES vectors.

The array does not need a second copy of its storage. Its orientation alternates every LANES accepted vectors. In one window, incoming vectors fill successive columns and outgoing vectors are taken from successive columns. In the next window, both writing and reading move along successive rows. A block written along columns is therefore read back along rows, and the reverse, which transposes it while the following block fills the space just freed. Every cell has a two-way input selector (row load or column load). Every output lane has one selector over the 2·LANES−1 distinct cells of its own row and its own column.

Output is flagged valid one cycle after an accepted input, once the first full block has been stored. A separate output reports the orientation of the window in which the vector on the output was read.

Top module: `xpose_buf`

## Requirements
- R1: While reset is asserted and in the first cycle after it, outValid and outRowMode are 0 and outVec is all zeros. After reset the first window is column-wise.
- R2: The first LANES accepted vectors after reset give outValid = 0 in the cycle after each of them.
- R3: After the first LANES accepted vectors, outValid in a cycle equals inValid in the cycle before. outValid is never 1 unless the previous cycle accepted a vector.
- R4: Let vector k (k = 0..LANES−1) be accepted in block b ≥ 1. In the next cycle, lane i of outVec equals lane k of the i-th vector accepted in block b−1. Lane i occupies bits [i·DW +: DW] on both inVec and outVec.
- R5: The orientation flips after each LANES accepted vectors. In the cycle after a vector of block b is accepted, outRowMode = b mod 2, where 0 means column-wise and 1 means row-wise.
- R6: A cycle with inValid = 0 changes no cell, no step position and no orientation. In the next cycle outVec and outRowMode keep their previous values and outValid = 0.
- R7: A cell read and written in the same cycle gives its old content on the output, not the value being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input vector is present this cycle |
| inVec | input | LANES*DW | Input vector, lane i at [i*DW +: DW] |
| outValid | output | 1 | Output vector holds transposed data |
| outVec | output | LANES*DW | Output vector, lane i at [i*DW +: DW] |
| outRowMode | output | 1 | Orientation of the window the output was read in (0 column, 1 row) |

## Verification
The bench builds the block with its defaults, LANES = 4 and DW = 16. This is small enough that many blocks run in a short test, so both orientations are entered many times, and every position of the step counter meets idle gaps on either side. Four lanes include a diagonal cell that is shared by a row and a column. They also include cells on both sides of that diagonal in each selector, which exercises every branch of the selector index that skips the diagonal. The 16-bit data carries random values wide enough that a lane or cell mix-up cannot go unseen.

// File: rtl/tpb_pkg.sv
package tpb_pkg;

  // Strobes handed from the sequencer to the cell array each cycle.
  typedef struct packed {
    logic wrEn;     // a vector is accepted this cycle
    logic rowMode;  // 1: current window works along rows
    logic emit;     // the vector read this cycle belongs to a complete block
  } tpbStrobe_t;

  function automatic int unsigned stepWidth(input int unsigned lanes);
    return (lanes > 1) ? $clog2(lanes) : 1;
  endfunction

endpackage

// File: rtl/tpb_ctrl.sv
module tpb_ctrl
  import tpb_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned SW    = stepWidth(LANES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output tpbStrobe_t    strobe,
  output logic [SW-1:0] stepIdx
);

  localparam logic [SW-1:0] LAST_STEP = SW'(LANES - 1);

  logic [SW-1:0] stepQ;
  logic          modeQ;
  logic          primedQ;
  logic          wrapNow;

  assign wrapNow = inValid && (stepQ == LAST_STEP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepQ   <= '0;
      modeQ   <= 1'b0;
      primedQ <= 1'b0;
    end else if (inValid) begin
      if (wrapNow) begin
        stepQ   <= '0;
        modeQ   <= ~modeQ;
        primedQ <= 1'b1;
      end else begin
        stepQ <= stepQ + SW'(1);
      end
    end
  end

  always_comb begin
    strobe.wrEn    = inValid;
    strobe.rowMode = modeQ;
    strobe.emit    = inValid && primedQ;
  end

  assign stepIdx = stepQ;

endmodule

// File: rtl/tpb_array.sv
module tpb_array
  import tpb_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned DW    = 16,
  parameter int unsigned SW    = stepWidth(LANES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  tpbStrobe_t          strobe,
  input  logic [SW-1:0]       stepIdx,
  input  logic [LANES*DW-1:0] inVec,
  output logic                outValid,
  output logic [LANES*DW-1:0] outVec,
  output logic                outRowMode
);

  localparam int unsigned CANDS = 2 * LANES - 1;
  localparam int unsigned XW    = (CANDS > 1) ? $clog2(CANDS) : 1;

  logic [DW-1:0] cellQ    [LANES][LANES];
  logic [DW-1:0] cellNext [LANES][LANES];
  logic          cellHit  [LANES][LANES];
  logic [DW-1:0] laneRd   [LANES];
  logic [LANES*DW-1:0] rdFlat;

  // Write side: each cell picks its row-wise or column-wise source.
  always_comb begin
    for (int r = 0; r < LANES; r++) begin
      for (int c = 0; c < LANES; c++) begin
        if (strobe.rowMode) begin
          cellHit[r][c]  = strobe.wrEn && (stepIdx == SW'(r));
          cellNext[r][c] = inVec[c*DW +: DW];
        end else begin
          cellHit[r][c]  = strobe.wrEn && (stepIdx == SW'(c));
          cellNext[r][c] = inVec[r*DW +: DW];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < LANES; r++)
        for (int c = 0; c < LANES; c++)
          cellQ[r][c] <= '0;
    end else begin
      for (int r = 0; r < LANES; r++)
        for (int c = 0; c < LANES; c++)
          if (cellHit[r][c]) cellQ[r][c] <= cellNext[r][c];
    end
  end

  // Read side: lane i selects among the cells of row i and column i,
  // the diagonal cell appearing once.
  for (genvar i = 0; i < LANES; i++) begin : gLane
    logic [DW-1:0] cand [CANDS];
    logic [XW-1:0] selIdx;

    for (genvar j = 0; j < LANES; j++) begin : gRowSrc
      assign cand[j] = cellQ[i][j];
    end

    for (genvar r = 0; r < LANES; r++) begin : gColSrc
      if (r < i) begin : gAbove
        assign cand[LANES + r] = cellQ[r][i];
      end else if (r > i) begin : gBelow
        assign cand[LANES + r - 1] = cellQ[r][i];
      end
    end

    always_comb begin
      if (!strobe.rowMode) begin
        selIdx = XW'(stepIdx);
      end else if (stepIdx == SW'(i)) begin
        selIdx = XW'(i);
      end else if (stepIdx < SW'(i)) begin
        selIdx = XW'(LANES) + XW'(stepIdx);
      end else begin
        selIdx = XW'(LANES) + XW'(stepIdx) - XW'(1);
      end
    end

    assign laneRd[i] = cand[selIdx];
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) rdFlat[i*DW +: DW] = laneRd[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outVec     <= '0;
      outRowMode <= 1'b0;
      outValid   <= 1'b0;
    end else begin
      outValid <= strobe.emit;
      if (strobe.wrEn) begin
        outVec     <= rdFlat;
        outRowMode <= strobe.rowMode;
      end
    end
  end

endmodule

// File: rtl/xpose_buf.sv
module xpose_buf
  import tpb_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned DW    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [LANES*DW-1:0] inVec,
  output logic                outValid,
  output logic [LANES*DW-1:0] outVec,
  output logic                outRowMode
);

  localparam int unsigned SW = stepWidth(LANES);

  tpbStrobe_t    strobe;
  logic [SW-1:0] stepIdx;

  tpb_ctrl #(.LANES(LANES), .SW(SW)) ctrlI (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .stepIdx (stepIdx)
  );

  tpb_array #(.LANES(LANES), .DW(DW), .SW(SW)) arrI (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .stepIdx    (stepIdx),
    .inVec      (inVec),
    .outValid   (outValid),
    .outVec     (outVec),
    .outRowMode (outRowMode)
  );

endmodule

// File: rtl/tpb_chk.sv
module tpb_chk #(
  parameter int unsigned LANES = 4,
  parameter int unsigned DW    = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic [LANES*DW-1:0] inVec,
  input logic                outValid,
  input logic [LANES*DW-1:0] outVec,
  input logic                outRowMode
);

  localparam int unsigned CW = $clog2(LANES + 1);
  localparam logic [CW-1:0] FULL = CW'(LANES);

  logic [CW-1:0] seenCnt;
  logic [CW-1:0] phaseCnt;
  logic          blkPar;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenCnt  <= '0;
      phaseCnt <= '0;
      blkPar   <= 1'b0;
    end else if (inValid) begin
      if (seenCnt != FULL) seenCnt <= seenCnt + CW'(1);
      if (phaseCnt == FULL - CW'(1)) begin
        phaseCnt <= '0;
        blkPar   <= ~blkPar;
      end else begin
        phaseCnt <= phaseCnt + CW'(1);
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> (!outValid && !outRowMode));

  // R2
  first_block_hidden_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($past(seenCnt) == FULL));

  // R3
  valid_follows_input_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && seenCnt == FULL) |=> outValid);

  // R5
  orient_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (outRowMode == $past(blkPar)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outVec) && $stable(outRowMode) && !outValid));

  // R3
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

bind xpose_buf tpb_chk #(.LANES(LANES), .DW(DW)) chkI (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inVec      (inVec),
  .outValid   (outValid),
  .outVec     (outVec),
  .outRowMode (outRowMode)
);

// File: tb/xpose_buf_test.sv
module xpose_buf_test;

  localparam int unsigned LANES = 4;
  localparam int unsigned DW    = 16;
  localparam time CLK_PERIOD    = 10ns;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                inValid = 1'b0;
  logic [LANES*DW-1:0] inVec = '0;
  logic                outValid;
  logic [LANES*DW-1:0] outVec;
  logic                outRowMode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model of the block sequence
  logic [DW-1:0]       prevBlk [LANES][LANES];
  logic [DW-1:0]       curBlk  [LANES][LANES];
  int                  kPos = 0;
  int                  blkNo = 0;
  logic [LANES*DW-1:0] lastOut = '0;
  logic                lastOrient = 1'b0;

  xpose_buf #(.LANES(LANES), .DW(DW)) uut (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inVec      (inVec),
    .outValid   (outValid),
    .outVec     (outVec),
    .outRowMode (outRowMode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [LANES*DW-1:0] expTranspose(input int k);
    logic [LANES*DW-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*DW +: DW] = prevBlk[i][k];
    return v;
  endfunction

  // Drive one cycle, then check the outputs that reflect it.
  task automatic drive(input bit v, input logic [LANES*DW-1:0] vec, input bit r7Check);
    logic [LANES*DW-1:0] expOut;
    logic                expOrient;
    bit                  expValid;
    inValid = v;
    inVec   = vec;
    if (v) begin
      expValid  = (blkNo >= 1);
      expOrient = blkNo[0];
      expOut    = (blkNo >= 1) ? expTranspose(kPos) : 'x;
    end else begin
      expValid  = 0;
      expOrient = lastOrient;
      expOut    = lastOut;
    end
    @(negedge clk);
    if (v && blkNo == 0)
      chk(outValid == 1'b0, "R2 first block output flagged", 64'(outValid), 64'(0));
    else if (v)
      chk(outValid == 1'b1, "R3 output valid after accepted input", 64'(outValid), 64'(1));
    else
      chk(outValid == 1'b0 && outVec == expOut, "R6 idle cycle holds output",
          64'(outVec), 64'(expOut));
    chk(outRowMode == expOrient, v ? "R5 orientation" : "R6 orientation held",
        64'(outRowMode), 64'(expOrient));
    if (v && blkNo >= 1) begin
      chk(outVec == expOut, "R4 transposed vector", 64'(outVec), 64'(expOut));
      if (r7Check)
        chk(outVec[0 +: DW] == prevBlk[0][kPos] && outVec[0 +: DW] != vec[0 +: DW],
            "R7 old cell content read", 64'(outVec[0 +: DW]), 64'(prevBlk[0][kPos]));
    end
    lastOut    = outVec;
    lastOrient = outRowMode;
    if (v) begin
      for (int i = 0; i < LANES; i++) curBlk[kPos][i] = vec[i*DW +: DW];
      kPos++;
      if (kPos == LANES) begin
        kPos = 0;
        blkNo++;
        for (int a = 0; a < LANES; a++)
          for (int b = 0; b < LANES; b++) prevBlk[a][b] = curBlk[a][b];
      end
    end
  endtask

  function automatic logic [LANES*DW-1:0] patVec(input int base);
    logic [LANES*DW-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*DW +: DW] = DW'(base * 16 + i + 1);
    return v;
  endfunction

  function automatic logic [LANES*DW-1:0] rndVec();
    logic [LANES*DW-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*DW +: DW] = DW'($urandom());
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0 && outRowMode == 1'b0 && outVec == '0, "R1 reset state",
        64'(outVec), 64'(0));
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0 && outRowMode == 1'b0, "R1 after release",
        64'({outValid, outRowMode}), 64'(0));

    // directed: first block, counting pattern (column-wise window)
    for (int k = 0; k < LANES; k++) drive(1, patVec(k), 0);
    // second block with idle gaps in between; same-cycle overwrite check
    for (int k = 0; k < LANES; k++) begin
      drive(1, patVec(k + 8), 1);
      drive(0, rndVec(), 0);
    end
    // third block back to back, then a long idle run
    for (int k = 0; k < LANES; k++) drive(1, patVec(k + 4), 1);
    repeat (5) drive(0, rndVec(), 0);
    // all-ones and zeros corner data
    for (int k = 0; k < LANES; k++) drive(1, '1, 0);
    for (int k = 0; k < LANES; k++) drive(1, '0, 0);

    // random traffic
    for (int n = 0; n < 2000; n++) begin
      drive(($urandom() % 4) != 0, rndVec(), 0);
    end

    summary();
  end

endmodule